// File: doc/BRIEF.md
# AUX Channel Transaction Engine

A register-driven engine that runs one request/reply exchange on a DisplayPort AUX channel. A host sees one control/status word and five 32-bit data words. It fills the data words with up to 20 request bytes, then writes the control word with the start bit and a byte count. The engine waits out a programmable sync interval and streams the bytes over a byte handshake. It then waits for a reply or a timeout, writes the reply bytes into the same data words and reports the outcome in sticky status flags.

The line coding stays outside the block. Toward the link there is a byte stream with a valid/ready handshake and a last marker. Coming back there is a reply byte stream with a last marker and a receive-error strobe. The engine can also splice an 8-byte key into the request after the header. The key comes from a private input that the host cannot read or write. All timing counts in ticks of a 2 MHz timebase. The divider for that timebase is derived from the reference clock frequency.

Top module: `aux_xact_engine`

## Requirements
- R1: After reset the control word (address 0) reads 0x00003000, meaning idle, no flags and precharge field 3. All data words (addresses 1 to 5) read 0, `irq` is low and `tx_valid` is low.
- R2: A started request sends exactly N bytes, where N is the size field (bits 20:16) clamped to 20. Byte i comes from data word i/4 at bits [31-8*(i%4) -: 8], so the order is big-endian. `tx_last` is high only with the final byte. A byte is held stable until `tx_ready` accepts it.
- R3: An idle write to address 0 with bit 31 set starts a transfer. Bit 31 reads 1 until the transfer ends and 0 afterwards. `tx_valid` is asserted only while busy.
- R4: Reply bytes received while waiting are stored big-endian from byte 0 of the data words. `rx_last` ends the transfer and sets the done flag (bit 30). The size field then reads the number of reply bytes. Data bytes beyond the reply keep their earlier values.
- R5: A reply longer than 20 bytes stores only its first 20 bytes. The size field reports the full count, saturating at 31.
- R6: The done (30), timeout (29) and receive-error (28) flags are sticky. Each is cleared only by writing 1 to its own bit.
- R7: `irq` is high exactly while the interrupt-enable bit (27) is set and at least one of the three flags is set.
- R8: While busy, writes to the data words are ignored. Control writes then change nothing except the write-1-to-clear flags.
- R9: The first request byte is presented exactly DIV*2*(26+2*P) clock cycles after the start write. P is the precharge field (bits 15:12) and DIV is REF_KHZ/2000 rounded to nearest.
- R10: With no reply, the transfer ends DIV*2*T cycles after the final byte is accepted. T is 400, 600, 800 or 1600 for timeout select (bits 25:24) values 0 to 3. The timeout flag is set, done stays clear and the size field reads 0.
- R11: With the key bit (26) set, the 8 bytes of `key_in` are sent most significant byte first. They follow request byte min(N,4)-1, and the remaining request bytes come after them.
- R12: `rx_err` while waiting ends the transfer with the receive-error flag set and done clear. The size field then holds the reply bytes already received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register select: 0 control/status, 1..5 data words |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tx_valid | output | 1 | Request byte available |
| tx_ready | input | 1 | Link accepts the request byte |
| tx_byte | output | 8 | Request byte |
| tx_last | output | 1 | Final request byte |
| rx_valid | input | 1 | Reply byte present |
| rx_byte | input | 8 | Reply byte |
| rx_last | input | 1 | Final reply byte |
| rx_err | input | 1 | Link reports a corrupted reply |
| key_in | input | 64 | Private key bytes for splicing |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach from the ports is a control write that lands while a transfer is in flight. To set it up, the stimulus leaves the done flag of the previous exchange uncleared and starts a new request. During the sync interval it writes a data word and then a control word. That control word carries a different size, the interrupt enable and the done clear bit. Readback and the number of bytes that reach the link then show that only the flag clear took effect. The timing requirements are checked by counting exact cycles for several precharge and timeout settings, with a reference frequency chosen so that the divider has to round up.

// File: rtl/aux_xact_engine.sv
module aux_xact_engine #(
  parameter int REF_KHZ     = 100000,
  parameter int NWORDS      = 5,
  parameter int PRE_MIN_US  = 10,
  parameter int PREAMBLE_US = 16,
  parameter int PRE_DEF     = 3,
  parameter int KEY_BYTES   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             bus_addr,
  input  logic                   bus_wr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic [7:0]             tx_byte,
  output logic                   tx_last,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_byte,
  input  logic                   rx_last,
  input  logic                   rx_err,
  input  logic [8*KEY_BYTES-1:0] key_in,
  output logic                   irq
);
  localparam int DIV  = ((REF_KHZ + 1000) / 2000) < 1 ? 1 : (REF_KHZ + 1000) / 2000;
  localparam int DW   = DIV > 1 ? $clog2(DIV) : 1;
  localparam int MAXB = 4 * NWORDS;
  localparam int AW   = $clog2(NWORDS);
  localparam int PW   = $clog2(MAXB + KEY_BYTES + 1) + 1;
  localparam int TW   = 14;

  typedef enum logic [1:0] {S_IDLE, S_SYNC, S_SEND, S_WAIT} st_t;

  st_t            state_q;
  logic [31:0]    data_q [NWORDS];
  logic           done_q, tout_q, rxerr_q, irqen_q, key_q;
  logic [1:0]     tsel_q;
  logic [3:0]     pre_q;
  logic [4:0]     size_q, rxn_q;
  logic [DW-1:0]  div_q;
  logic [TW-1:0]  tcnt_q;
  logic [PW-1:0]  pos_q;

  logic busy;
  assign busy = state_q != S_IDLE;

  wire ctl_wr = bus_wr && bus_addr == 3'd0;
  wire dat_wr = bus_wr && bus_addr != 3'd0 && 32'(bus_addr) <= NWORDS && !busy;
  wire start  = ctl_wr && !busy && bus_wdata[31];
  wire tick   = div_q == DW'(DIV - 1);

  wire [4:0] wsz = 32'(bus_wdata[20:16]) > MAXB ? 5'(MAXB) : bus_wdata[20:16];

  logic [TW-1:0] to_ticks, tlim;
  always_comb begin
    case (tsel_q)
      2'd0:    to_ticks = TW'(800);
      2'd1:    to_ticks = TW'(1200);
      2'd2:    to_ticks = TW'(1600);
      default: to_ticks = TW'(3200);
    endcase
    tlim = (state_q == S_SYNC) ? TW'(2 * (PRE_MIN_US + PREAMBLE_US)) + TW'({pre_q, 2'b00})
                               : to_ticks;
  end
  wire expire = tick && tcnt_q == tlim - TW'(1);

  wire [PW-1:0] hdr   = size_q < 5'd4 ? PW'(size_q) : PW'(4);
  wire [PW-1:0] total = PW'(size_q) + (key_q ? PW'(KEY_BYTES) : PW'(0));
  wire          in_key = key_q && pos_q >= hdr && pos_q < hdr + PW'(KEY_BYTES);
  wire [PW-1:0] kidx  = pos_q - hdr;
  wire [PW-1:0] ridx  = (key_q && pos_q >= hdr + PW'(KEY_BYTES)) ? pos_q - PW'(KEY_BYTES) : pos_q;
  wire [31:0]   rword = data_q[ridx[AW+1:2]];
  wire [8*KEY_BYTES-1:0] kshift = key_in >> {PW'(KEY_BYTES - 1) - kidx, 3'b000};

  assign tx_valid = state_q == S_SEND;
  assign tx_byte  = in_key ? kshift[7:0] : rword[{~ridx[1:0], 3'b000} +: 8];
  assign tx_last  = tx_valid && pos_q == total - PW'(1);
  assign irq      = irqen_q && (done_q || tout_q || rxerr_q);

  wire [4:0] rxn_nx = rxn_q == 5'd31 ? rxn_q : rxn_q + 5'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      for (int i = 0; i < NWORDS; i++) data_q[i] <= '0;
      done_q  <= 1'b0;
      tout_q  <= 1'b0;
      rxerr_q <= 1'b0;
      irqen_q <= 1'b0;
      key_q   <= 1'b0;
      tsel_q  <= '0;
      pre_q   <= 4'(PRE_DEF);
      size_q  <= '0;
      rxn_q   <= '0;
      div_q   <= '0;
      tcnt_q  <= '0;
      pos_q   <= '0;
    end else begin
      if (ctl_wr) begin
        if (bus_wdata[30]) done_q  <= 1'b0;
        if (bus_wdata[29]) tout_q  <= 1'b0;
        if (bus_wdata[28]) rxerr_q <= 1'b0;
        if (!busy) begin
          irqen_q <= bus_wdata[27];
          key_q   <= bus_wdata[26];
          tsel_q  <= bus_wdata[25:24];
          size_q  <= wsz;
          pre_q   <= bus_wdata[15:12];
        end
      end
      if (dat_wr) data_q[AW'(bus_addr - 3'd1)] <= bus_wdata;

      if (state_q == S_SYNC || state_q == S_WAIT) begin
        div_q <= tick ? '0 : div_q + DW'(1);
        if (tick) tcnt_q <= tcnt_q + TW'(1);
      end

      case (state_q)
        S_IDLE: if (start) begin
          state_q <= S_SYNC;
          div_q   <= '0;
          tcnt_q  <= '0;
          pos_q   <= '0;
          rxn_q   <= '0;
        end
        S_SYNC: if (expire) begin
          state_q <= (total == '0) ? S_WAIT : S_SEND;
          div_q   <= '0;
          tcnt_q  <= '0;
        end
        S_SEND: if (tx_ready) begin
          pos_q <= pos_q + PW'(1);
          if (pos_q == total - PW'(1)) begin
            state_q <= S_WAIT;
            div_q   <= '0;
            tcnt_q  <= '0;
          end
        end
        S_WAIT: begin
          if (rx_err) begin
            rxerr_q <= 1'b1;
            size_q  <= rxn_q;
            state_q <= S_IDLE;
          end else if (rx_valid) begin
            if (32'(rxn_q) < MAXB) data_q[rxn_q[AW+1:2]][{~rxn_q[1:0], 3'b000} +: 8] <= rx_byte;
            rxn_q <= rxn_nx;
            if (rx_last) begin
              done_q  <= 1'b1;
              size_q  <= rxn_nx;
              state_q <= S_IDLE;
            end
          end else if (expire) begin
            tout_q  <= 1'b1;
            size_q  <= rxn_q;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == 3'd0)
      bus_rdata = {busy, done_q, tout_q, rxerr_q, irqen_q, key_q, tsel_q, 3'b000,
                   size_q, pre_q, 12'h000};
    else if (32'(bus_addr) <= NWORDS)
      bus_rdata = data_q[AW'(bus_addr - 3'd1)];
  end
endmodule

// File: rtl/aux_xact_engine_chk.sv
module aux_xact_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_byte,
  input logic       tx_last,
  input logic       irq,
  input logic       busy,
  input logic       done_q,
  input logic       tout_q,
  input logic       rxerr_q,
  input logic       irqen_q
);
  p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte) && $stable(tx_last));

  p_tx_when_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy);

  p_done_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy) && !busy);

  p_tout_not_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tout_q) |-> !$rose(done_q) && !busy);

  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(busy) || !$past(irqen_q));

  p_rxerr_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxerr_q) |-> $past(busy) && !busy);
endmodule

bind aux_xact_engine aux_xact_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_byte(tx_byte), .tx_last(tx_last), .irq(irq), .busy(busy),
  .done_q(done_q), .tout_q(tout_q), .rxerr_q(rxerr_q), .irqen_q(irqen_q)
);

// File: tb/aux_xact_engine_tb.sv
module aux_xact_engine_tb;
  localparam int REF = 7000;
  localparam int DIV = (REF + 1000) / 2000;
  localparam logic [63:0] KEY = 64'h0123_4567_89AB_CDEF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tx_valid, tx_ready = 1'b1, tx_last;
  logic [7:0] tx_byte;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
  logic [7:0] rx_byte = '0;
  logic irq;

  always #5 clk = ~clk;

  aux_xact_engine #(.REF_KHZ(REF)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_byte(tx_byte), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last),
    .rx_err(rx_err), .key_in(KEY), .irq(irq));

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [7:0] req [20];
  logic [7:0] rep [32];
  logic [7:0] txbuf [64];
  logic [7:0] expv [64];
  int txcnt = 0, lastcnt = 0, lastpos = -1;
  bit sent_done = 1'b0;
  bit stall_en = 1'b0;
  logic [7:0] lfsr = 8'hB5;

  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready = stall_en ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    if (tx_valid && tx_ready) begin
      if (txcnt < 64) txbuf[txcnt] = tx_byte;
      if (tx_last) begin
        lastcnt++;
        lastpos = txcnt;
        sent_done = 1'b1;
      end
      txcnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] mk(input bit b, input bit ie, input bit k,
                                     input int ts, input int sz, input int pre);
    return {b, 3'b000, ie, k, 2'(ts), 3'b000, 5'(sz), 4'(pre), 12'h000};
  endfunction

  task automatic load(input int seed);
    for (int i = 0; i < 20; i++) req[i] = 8'(seed * 7 + i * 13 + 1);
    for (int w = 0; w < 5; w++)
      wr(3'(w + 1), {req[4*w], req[4*w+1], req[4*w+2], req[4*w+3]});
  endtask

  task automatic start(input logic [31:0] c);
    txcnt = 0; lastcnt = 0; lastpos = -1; sent_done = 1'b0;
    wr(3'd0, c);
  endtask

  task automatic reply(input int m, input int seed, input bit err);
    for (int i = 0; i < 32; i++) rep[i] = 8'(8'hA0 ^ 8'(seed * 5 + i * 3));
    wait (sent_done);
    @(negedge clk);
    for (int i = 0; i < m; i++) begin
      rx_valid = 1'b1; rx_byte = rep[i]; rx_last = (i == m - 1) && !err;
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0;
    if (err) begin
      rx_err = 1'b1;
      @(negedge clk);
      rx_err = 1'b0;
    end
  endtask

  task automatic wait_idle(output logic [31:0] st);
    st = 32'hFFFF_FFFF;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd0, st);
      if (!st[31]) break;
    end
  endtask

  task automatic check_tx(input int n, input string tag);
    bit ok = (txcnt == n);
    chk(ok, {tag, " count"}, 32'(txcnt), 32'(n));
    ok = 1'b1;
    for (int i = 0; i < n && i < 64; i++) if (txbuf[i] !== expv[i]) ok = 1'b0;
    chk(ok, {tag, " bytes"}, 32'(txbuf[0]), 32'(expv[0]));
    chk(lastcnt == 1 && lastpos == n - 1, {tag, " last"}, 32'(lastpos), 32'(n - 1));
  endtask

  task automatic check_data(input int m, input string tag);
    logic [31:0] d;
    logic [7:0] e, a;
    bit ok = 1'b1;
    logic [31:0] fa = '0, fe = '0;
    for (int w = 0; w < 5; w++) begin
      rd(3'(w + 1), d);
      for (int b = 0; b < 4; b++) begin
        a = d[31 - 8*b -: 8];
        e = (4*w + b < m) ? rep[4*w + b] : req[4*w + b];
        if (a !== e && ok) begin ok = 1'b0; fa = 32'(a); fe = 32'(e); end
      end
    end
    chk(ok, tag, fa, fe);
  endtask

  initial begin
    #(10 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] st, d;
    int n, m, cyc, exp_c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, st);
    chk(st == 32'h0000_3000, "R1 ctrl reset", st, 32'h0000_3000);
    for (int w = 1; w <= 5; w++) begin
      rd(3'(w), d);
      chk(d == 0, "R1 data reset", d, 0);
    end
    chk(irq == 1'b0 && tx_valid == 1'b0, "R1 irq/tx idle", {30'd0, irq, tx_valid}, 0);

    // R2 R3 R4 R6 size sweep
    for (int k = 1; k <= 20; k++) begin
      n = k; m = 21 - k;
      stall_en = k[0];
      load(k);
      for (int i = 0; i < 20; i++) expv[i] = req[i];
      start(mk(1, 0, 0, 0, n, 3));
      rd(3'd0, st);
      chk(st[31] == 1'b1, "R3 busy while running", st, 32'h8000_0000);
      reply(m, k, 1'b0);
      wait_idle(st);
      check_tx(n, "R2 sweep");
      chk(st[31:28] == 4'b0100 && st[20:16] == 5'(m), "R4 status size", st, {4'b0100, 11'd0, 5'(m), 12'd0});
      check_data(m, "R4 reply data");
      wr(3'd0, 32'h4000_0000);
      rd(3'd0, st);
      chk(st[30] == 1'b0, "R6 done w1c", st, 0);
    end
    stall_en = 1'b0;

    // R2 clamp of size above 20
    load(40);
    for (int i = 0; i < 20; i++) expv[i] = req[i];
    start(mk(1, 0, 0, 0, 25, 0));
    reply(1, 2, 1'b0);
    wait_idle(st);
    check_tx(20, "R2 clamp");

    // R6 stickiness and selective clear, R7 irq
    rd(3'd0, st);
    chk(st[30] == 1'b1, "R6 done sticky", st, 32'h4000_0000);
    wr(3'd0, 32'h2000_0000 | mk(0, 1, 0, 0, 0, 0));
    rd(3'd0, st);
    chk(st[30] == 1'b1, "R6 other bit no clear", st, 32'h4000_0000);
    chk(irq == 1'b1, "R7 irq on", 32'(irq), 1);
    wr(3'd0, 32'h4000_0000 | mk(0, 1, 0, 0, 0, 0));
    chk(irq == 1'b0, "R7 irq off after clear", 32'(irq), 0);
    load(3);
    start(mk(1, 0, 0, 0, 2, 0));
    reply(2, 9, 1'b0);
    wait_idle(st);
    chk(st[30] == 1'b1 && irq == 1'b0, "R7 no irq when disabled", {st[31:1], irq}, 32'h4000_0000);

    // R8 writes during busy (done still set from previous)
    load(5);
    for (int i = 0; i < 20; i++) expv[i] = req[i];
    start(mk(1, 0, 0, 0, 4, 4));
    wr(3'd2, 32'hDEAD_BEEF);
    rd(3'd2, d);
    chk(d == {req[4], req[5], req[6], req[7]}, "R8 data write ignored", d, {req[4], req[5], req[6], req[7]});
    wr(3'd0, 32'h4000_0000 | mk(1, 1, 1, 3, 9, 1));
    rd(3'd0, st);
    chk(st[31:16] == 16'h8000 + 16'd4, "R8 ctrl write ignored, done cleared", st, 32'h8004_0000);
    reply(3, 4, 1'b0);
    wait_idle(st);
    check_tx(4, "R8 original size");
    wr(3'd0, 32'h7000_0000);

    // R9 sync length for several precharge values
    foreach (expv[i]) expv[i] = 8'h00;
    for (int p = 0; p < 3; p++) begin
      int pre = (p == 0) ? 0 : (p == 1) ? 5 : 15;
      load(60 + p);
      start(mk(1, 0, 0, 0, 1, pre));
      cyc = 0;
      while (!tx_valid && cyc < 5000) begin
        @(posedge clk); cyc++; @(negedge clk);
      end
      exp_c = DIV * 2 * (26 + 2 * pre);
      chk(cyc == exp_c, "R9 sync cycles", 32'(cyc), 32'(exp_c));
      reply(1, 1, 1'b0);
      wait_idle(st);
      wr(3'd0, 32'h7000_0000);
    end

    // R10 timeout selects
    for (int s = 0; s < 2; s++) begin
      load(70 + s);
      start(mk(1, 0, 0, s, 2, 0));
      wait (sent_done);
      bus_addr = 3'd0;
      cyc = 0;
      do begin
        @(posedge clk); cyc++; @(negedge clk); #1;
      end while (bus_rdata[31] && cyc < 20000);
      exp_c = DIV * 2 * (s == 0 ? 400 : 600) + 1;
      chk(cyc == exp_c, "R10 timeout cycles", 32'(cyc), 32'(exp_c));
      rd(3'd0, st);
      chk(st[30:28] == 3'b010 && st[20:16] == 0, "R10 timeout flags", st, 32'h2000_0000);
      wr(3'd0, 32'h7000_0000);
    end

    // R11 key insertion, long and short request
    for (int c = 0; c < 2; c++) begin
      n = (c == 0) ? 6 : 2;
      load(80 + c);
      m = 0;
      for (int i = 0; i < (n < 4 ? n : 4); i++) expv[m++] = req[i];
      for (int i = 0; i < 8; i++) expv[m++] = KEY[63 - 8*i -: 8];
      for (int i = 4; i < n; i++) expv[m++] = req[i];
      start(mk(1, 0, 1, 0, n, 0));
      reply(1, 3, 1'b0);
      wait_idle(st);
      check_tx(n + 8, "R11 key splice");
      wr(3'd0, 32'h7000_0000);
    end

    // R5 overlong reply
    load(90);
    start(mk(1, 0, 0, 0, 3, 0));
    reply(23, 6, 1'b0);
    wait_idle(st);
    chk(st[30] == 1'b1 && st[20:16] == 5'd23, "R5 size reports 23", st, 32'h4017_0000);
    check_data(20, "R5 first 20 stored");
    wr(3'd0, 32'h7000_0000);

    // R12 receive error
    load(95);
    start(mk(1, 1, 0, 0, 3, 0));
    reply(2, 7, 1'b1);
    wait_idle(st);
    chk(st[31:28] == 4'b0001 && st[20:16] == 5'd2, "R12 rx error status", st, 32'h1002_0000);
    chk(irq == 1'b1, "R12 irq from rx error", 32'(irq), 1);
    wr(3'd0, 32'h1000_0000);
    rd(3'd0, st);
    chk(st[28] == 1'b0 && irq == 1'b0, "R6 rx error w1c", st, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule